// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Lane Writes

This block is a single-port synchronous static memory with a shared word width of 18, 32 or 36 bits. On each rising clock edge it captures the address, the write word and every control input. It then carries out that one access during the cycle that follows. A write retires into the array at the end of that cycle and needs no pulse timing from outside. A read is flow-through: the stored word at the captured address reaches the read port during the same cycle, with no output register in the path.

Three chip enables of mixed polarity select the memory. A sleep input turns captured accesses into no-ops and leaves the contents intact. Writes are chosen either wholesale, through a global write that forces every lane, or per lane, through a lane-write enable that qualifies individual lane strobes. Burst addresses come from an external sequencer. The shared pad bus is outside the block and is built from the write-data input, the read-data output and a drive flag. The port accepts one access in every cycle and never applies back-pressure, so it has no valid/ready pair.

Top module: `fts_ram`

## Requirements
- R1: Address, write data and all controls are sampled only at the rising clock edge. Changing the address after the edge does not change the read data of the current cycle.
- R2: When gw_n is low on a selected edge, every lane of the word is written, whatever bwe_n and bw_n hold.
- R3: When gw_n is high, lane i is written only if bwe_n is low and bw_n[i] is low. Lanes that are not written keep their old contents.
- R4: A selected access that writes no lane is a read cycle. This happens when gw_n is high and either bwe_n is high or all bw_n bits are high. During a write cycle the drive flag is low and rd_data is zero.
- R5: The block is selected when ce_n is low, ce2 is high and ce2_n is low. Any other combination, sampled at a single edge, makes the following cycle idle: nothing is written and nothing is driven.
- R6: rd_drive is high exactly when the current cycle is a selected read and oe_n is low. oe_n acts without a clock edge. rd_data is zero whenever rd_drive is low.
- R7: During a read cycle, rd_data equals the stored word at the captured address. A write captured at the previous edge is already visible.
- R8: When sleep is high at an edge, the access sampled there is ignored, nothing is driven in the following cycle, and the array contents are retained.
- R9: Lane i occupies word bits [i*LANE_W +: LANE_W]. The 18-bit width has 2 lanes of 9 bits, the 32-bit width has 4 lanes of 8 bits, and the 36-bit width has 4 lanes of 9 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single rising-edge clock |
| rst_n | input | 1 | Active-low reset of the capture registers |
| addr | input | ADDR_W | Word address |
| wr_data | input | WORD_W | Write word from the pad bus |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Snooze request, active high |
| rd_data | output | WORD_W | Read word, zero when not driven |
| rd_drive | output | 1 | Pad bus drive enable |

## Verification
A write that retires at an edge and a read captured at that same edge fall in the same cycle. The bench provokes this by issuing a lane write and then, at the very next edge, a read of the same address. It judges the read data in that cycle against a shadow memory that already holds the merged lanes. A second overlap pairs an asynchronous oe_n change with an open read cycle, and the drive flag is checked on both sides of the change within one clock period.

// File: rtl/fts_ram_pkg.sv
package fts_ram_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_e;

  function automatic int lanes_for(input int width);
    return (width == 18) ? 2 : 4;
  endfunction
endpackage

// File: rtl/fts_ram_ctl.sv
module fts_ram_ctl
  import fts_ram_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce2_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] wdata_q,
  output logic [LANES-1:0]  lane_we,
  output op_e               op_q
);
  logic             chosen;
  logic [LANES-1:0] mask_d;
  logic [LANES-1:0] mask_q;
  op_e              op_d;

  // Selection and lane decode from the raw pins.
  always_comb begin
    chosen = !ce_n && ce2 && !ce2_n && !sleep;
    if (!gw_n)       mask_d = '1;
    else if (!bwe_n) mask_d = ~bw_n;
    else             mask_d = '0;
    if (!chosen)        op_d = OP_IDLE;
    else if (|mask_d)   op_d = OP_WRITE;
    else                op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      mask_q <= '0;
    end else begin
      op_q   <= op_d;
      mask_q <= chosen ? mask_d : '0;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wr_data;
  end

  assign lane_we = (op_q == OP_WRITE) ? mask_q : '0;
endmodule

// File: rtl/fts_ram_array.sv
module fts_ram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] rword
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rword[g*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/fts_ram_obuf.sv
module fts_ram_obuf
  import fts_ram_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  op_e               op_q,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] rword,
  output logic              rd_drive,
  output logic [WORD_W-1:0] rd_data
);
  always_comb begin
    rd_drive = (op_q == OP_READ) && !oe_n;
    rd_data  = rd_drive ? rword : '0;
  end
endmodule

// File: rtl/fts_ram.sv
module fts_ram
  import fts_ram_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6,
  localparam int LANES  = lanes_for(WORD_W),
  localparam int LANE_W = WORD_W / LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce2_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_drive
);
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] rword;
  op_e               op_q;

  fts_ram_ctl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .sleep(sleep), .addr_q(addr_q), .wdata_q(wdata_q),
    .lane_we(lane_we), .op_q(op_q)
  );

  fts_ram_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .addr(addr_q), .wdata(wdata_q), .lane_we(lane_we), .rword(rword)
  );

  fts_ram_obuf #(.WORD_W(WORD_W)) u_obuf (
    .op_q(op_q), .oe_n(oe_n), .rword(rword), .rd_drive(rd_drive), .rd_data(rd_data)
  );
endmodule

// File: rtl/fts_ram_chk.sv
module fts_ram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             ce2,
  input logic             ce2_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bw_n,
  input logic             oe_n,
  input logic             sleep,
  input logic             rd_drive,
  input logic [LANES-1:0] lane_we
);
  logic picked;
  assign picked = !ce_n && ce2 && !ce2_n && !sleep;

  a_r6_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> !oe_n);

  a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(!ce_n && ce2 && !ce2_n) |-> (!rd_drive && lane_we == '0));

  a_r8_sleep_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> (!rd_drive && lane_we == '0));

  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(picked) && $past(!gw_n || (!bwe_n && !(&bw_n))))
      |-> !rd_drive);

  a_r2_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(picked) && $past(!gw_n)) |-> (&lane_we));

  a_r3_lane_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(picked) && $past(gw_n) && $past(!bwe_n))
      |-> (lane_we == ~$past(bw_n)));
endmodule

bind fts_ram fts_ram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
  .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep),
  .rd_drive(rd_drive), .lane_we(lane_we)
);

// File: tb/test_fts_ram.sv
module test_fts_ram;
  localparam int WW = 36;
  localparam int AW = 6;
  localparam int LN = 4;   // R9: 36-bit width has 4 lanes
  localparam int LW = 9;   // R9: of 9 bits each

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic          ce_n = 1'b1, ce2 = 1'b0, ce2_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [LN-1:0] bw_n = '1;
  logic          oe_n = 1'b1, sleep = 1'b0;
  logic [WW-1:0] rd_data;
  logic          rd_drive;

  logic [WW-1:0] shadow [1 << AW];
  int n_chk = 0;
  int n_bad = 0;

  fts_ram #(.WORD_W(WW), .ADDR_W(AW)) i_fts_ram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic drv, logic [WW-1:0] dat,
                       logic edrv, logic [WW-1:0] edat);
    n_chk++;
    if (drv !== edrv || dat !== edat) begin
      n_bad++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, drv, dat, edrv, edat);
    end
  endtask

  // Called at a negedge: applies one access, checks the cycle it produces,
  // returns at the next negedge. sel = {ce_n, ce2, ce2_n}.
  task automatic acc(string tag, logic [AW-1:0] a, logic [WW-1:0] d,
                     logic g, logic be, logic [LN-1:0] b, logic [2:0] sel,
                     logic slp, logic oe, logic late);
    logic          picked;
    logic [LN-1:0] mask;
    logic          wr, edrv;
    logic [WW-1:0] edat;
    addr = a; wr_data = d; gw_n = g; bwe_n = be; bw_n = b;
    {ce_n, ce2, ce2_n} = sel; sleep = slp; oe_n = oe;
    picked = !sel[2] && sel[1] && !sel[0] && !slp;
    mask = !g ? '1 : (!be ? ~b : '0);
    wr = picked && (mask != '0);
    edrv = picked && !wr && !oe;
    edat = edrv ? shadow[a] : '0;
    if (wr)
      for (int i = 0; i < LN; i++)
        if (mask[i]) shadow[a][i*LW +: LW] = d[i*LW +: LW];
    @(posedge clk);
    if (late) begin #2; addr = ~a; end
    @(negedge clk);
    check(tag, rd_drive, rd_data, edrv, edat);
  endtask

  function automatic logic [WW-1:0] pat(int k);
    return WW'(36'h9_A5C3_0F1E ^ (k * 36'h1_2345_6789));
  endfunction

  localparam logic [2:0] SEL = 3'b010;

  task automatic t_reset();
    check("R5 reset idle", rd_drive, rd_data, 1'b0, '0);
  endtask

  task automatic t_global();
    for (int k = 0; k < 16; k++)
      acc("R2 global write", AW'(k), pat(k), 1'b0, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
    // global write overrides lane controls that would write only one lane
    acc("R2 global overrides lanes", 6'd3, pat(40), 1'b0, 1'b0, 4'b1110, SEL, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 16; k++)
      acc("R7 read after global", AW'(k), '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lanes();
    logic [LN-1:0] pats [5] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b0101};
    for (int p = 0; p < 5; p++) begin
      acc("R3 lane write", 6'd5, pat(100 + p), 1'b1, 1'b0, pats[p], SEL, 1'b0, 1'b0, 1'b0);
      acc("R9 lane placement read", 6'd5, '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_nolane();
    acc("R4 bwe without strobes reads", 6'd6, pat(200), 1'b1, 1'b0, '1, SEL, 1'b0, 1'b0, 1'b0);
    acc("R4 strobes without bwe reads", 6'd6, pat(201), 1'b1, 1'b1, 4'b0000, SEL, 1'b0, 1'b0, 1'b0);
    acc("R4 write cycle not driven", 6'd6, pat(202), 1'b0, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
    acc("R4 read back", 6'd6, '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_deselect();
    acc("R5 ce_n high", 6'd7, pat(300), 1'b0, 1'b1, '1, 3'b110, 1'b0, 1'b0, 1'b0);
    acc("R5 ce2 low", 6'd7, pat(301), 1'b0, 1'b1, '1, 3'b000, 1'b0, 1'b0, 1'b0);
    acc("R5 ce2_n high", 6'd7, pat(302), 1'b0, 1'b1, '1, 3'b011, 1'b0, 1'b0, 1'b0);
    acc("R5 read deselected", 6'd7, '0, 1'b1, 1'b1, '1, 3'b110, 1'b0, 1'b0, 1'b0);
    acc("R5 contents kept", 6'd7, '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_oe();
    acc("R6 oe high read", 6'd8, '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b1, 1'b0);
    addr = 6'd8; gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; {ce_n, ce2, ce2_n} = SEL; oe_n = 1'b0;
    @(posedge clk); #2;
    check("R6 oe low drives", rd_drive, rd_data, 1'b1, shadow[8]);
    oe_n = 1'b1; #1;
    check("R6 oe release async", rd_drive, rd_data, 1'b0, '0);
    oe_n = 1'b0; #1;
    check("R6 oe reassert async", rd_drive, rd_data, 1'b1, shadow[8]);
    @(negedge clk);
  endtask

  task automatic t_capture();
    acc("R1 late address change", 6'd9, '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_b2b();
    acc("R7 lane write", 6'd10, pat(400), 1'b1, 1'b0, 4'b1010, SEL, 1'b0, 1'b0, 1'b0);
    acc("R7 next edge read merged", 6'd10, '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sleep();
    acc("R8 write in sleep", 6'd11, pat(500), 1'b0, 1'b1, '1, SEL, 1'b1, 1'b0, 1'b0);
    acc("R8 read in sleep", 6'd11, '0, 1'b1, 1'b1, '1, SEL, 1'b1, 1'b0, 1'b0);
    acc("R8 contents retained", 6'd11, '0, 1'b1, 1'b1, '1, SEL, 1'b0, 1'b0, 1'b0);
  endtask

  bit finished = 0;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20_000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    for (int k = 0; k < (1 << AW); k++) shadow[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_global();
    t_lanes();
    t_nolane();
    t_deselect();
    t_oe();
    t_capture();
    t_b2b();
    t_sleep();
    {ce_n, ce2, ce2_n} = 3'b110;
    @(negedge clk);
    finished = 1;
    summary();
  end
endmodule